// File: doc/BRIEF.md
# Phase-Modulo Clock-Enable Generator

This block turns a free-running reference clock into a sparse clock-enable pulse train whose average rate is the reference rate scaled by phase/modulo. An accumulator adds the phase once per reference cycle. Whenever the running sum reaches the modulo, the block emits a one-cycle enable and subtracts the modulo from the sum. Downstream logic clocked by the reference clock uses the enable to run at the derived rate without a second clock tree.

The configuration can be written in two ways. A direct write supplies enable, phase and modulo. A derive write supplies a requested and a base frequency, and the block computes the phase itself against a fixed all-ones modulo.

A zero-rate setting keeps the block enabled but silent. When the block is disabled it passes the reference through, so the enable stays high. A new setting never cuts a pulse interval short: it waits for the next wrap of the accumulator, unless the current setting produces no pulses at all.

Top module: `clken_dto`

## Requirements
- R1: While `rst` is high, `clk_en`, `active` and `sat_err` are 0. In the first cycle after reset the block is disabled, so `clk_en` reads 1 and `active` reads 0.
- R2: With the live enable bit at 0 (bypass), `clk_en` is 1 in every cycle and `active` is 0.
- R3: With enable 1 and 0 < phase ≤ modulo, the accumulator starts at 0 when the setting goes live. The j-th following cycle (j ≥ 1) has `clk_en` = floor(j·P/M) − floor((j−1)·P/M), which gives exactly P pulses in every M cycles.
- R4: A phase greater than a nonzero modulo is treated as equal to the modulo, so `clk_en` is 1 in every cycle and the accumulator never overflows.
- R5: With enable 1 and phase 0, `clk_en` stays 0 and `active` is 1. This is the zero-rate output, for example phase 0 with modulo 1.
- R6: With enable 1 and modulo 0, `clk_en` stays 0 and `active` is 1.
- R7: A write is captured at one clock edge. If the live setting is producing pulses, the captured setting takes effect at the edge of the next pulse. Otherwise it takes effect at the following edge. In both cases the accumulator restarts from 0.
- R8: A derive write with request Q and base B, both nonzero, sets enable 1, modulo 255 (all ones of the 8-bit width), and phase ceil(255·Q/B) = (255·Q + B − 1)/B.
- R9: When the derived phase exceeds 255, the phase is set to 255 and `sat_err` rises one cycle after the write. The next write of either kind recomputes `sat_err`, and a direct write clears it.
- R10: A derive write whose request or base is 0 gives phase 0, modulo 1 and enable 1 when `zero_opt` is 1. When `zero_opt` is 0 it gives enable 0, which is bypass.
- R11: If `cfg_wr` and `calc_wr` are both high in one cycle, the direct write wins and `sat_err` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Direct write strobe |
| cfg_en | input | 1 | Enable bit for a direct write |
| cfg_phase | input | 8 | Phase for a direct write |
| cfg_mod | input | 8 | Modulo for a direct write |
| calc_wr | input | 1 | Derive write strobe |
| calc_req | input | 16 | Requested frequency for a derive write |
| calc_base | input | 16 | Base (reference) frequency for a derive write |
| zero_opt | input | 1 | Selects zero-rate (1) or bypass (0) when a derive write has a zero operand |
| clk_en | output | 1 | Per-cycle clock enable |
| active | output | 1 | Live enable bit |
| sat_err | output | 1 | Last derive write saturated its phase |

## Verification
The pulse pattern is compared cycle by cycle against the floor formula over every phase from 0 to modulo+2 for several small moduli, and over a spread of phases at modulo 255. This separates off-by-one errors in the wrap comparison, the phase clamp, and the zero-phase and zero-modulo cases.

Derive writes use exact, fractional, tiny and overflowing ratios. Their results show whether the division rounds up, and whether the clamp and its flag are applied.

One test rewrites the setting in the middle of a pulse interval. It tells a deferred update from an immediate one.

Another test strobes both write kinds in the same cycle. It exposes a reversed priority between them.

// File: rtl/dto_pkg.sv
`timescale 1ns/1ps
package dto_pkg;
    parameter int unsigned ACC_W  = 8;
    parameter int unsigned FREQ_W = 16;
    localparam int unsigned NUM_W = FREQ_W + ACC_W + 1;
    localparam logic [ACC_W-1:0] CALC_MOD = '1;

    typedef struct packed {
        logic             en;
        logic [ACC_W-1:0] phase;
        logic [ACC_W-1:0] modulo;
    } dto_cfg_t;

    typedef struct packed {
        dto_cfg_t cfg;
        logic     sat;
    } derive_res_t;

    function automatic derive_res_t derive_phase(
        input logic [FREQ_W-1:0] want,
        input logic [FREQ_W-1:0] base,
        input logic              zopt
    );
        derive_res_t      res;
        logic [NUM_W-1:0] num;
        logic [NUM_W-1:0] quo;
        res = '0;
        num = '0;
        quo = '0;
        if (want != '0 && base != '0) begin
            num = NUM_W'(CALC_MOD) * NUM_W'(want) + NUM_W'(base) - NUM_W'(1);
            quo = num / NUM_W'(base);
            res.cfg.en     = 1'b1;
            res.cfg.modulo = CALC_MOD;
            if (quo > NUM_W'(CALC_MOD)) begin
                res.cfg.phase = CALC_MOD;
                res.sat       = 1'b1;
            end else begin
                res.cfg.phase = quo[ACC_W-1:0];
            end
        end else if (zopt) begin
            res.cfg.en     = 1'b1;
            res.cfg.phase  = '0;
            res.cfg.modulo = ACC_W'(1);
        end
        return res;
    endfunction
endpackage

// File: rtl/dto_phase_calc.sv
`timescale 1ns/1ps
module dto_phase_calc
    import dto_pkg::*;
(
    input  logic [FREQ_W-1:0] want,
    input  logic [FREQ_W-1:0] base,
    input  logic              zopt,
    output dto_cfg_t          cfg,
    output logic              sat
);
    derive_res_t res;

    always_comb begin
        res = derive_phase(want, base, zopt);
        cfg = res.cfg;
        sat = res.sat;
    end
endmodule

// File: rtl/dto_core.sv
`timescale 1ns/1ps
module dto_core
    import dto_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  dto_cfg_t wr_cfg,
    output logic     pulse,
    output logic     live_en
);
    dto_cfg_t         pend_q;
    dto_cfg_t         live_q;
    logic             pend_v_q;
    logic [ACC_W-1:0] acc_q;
    logic             out_q;

    logic             running;
    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   sum;
    logic             wrap;
    logic             load;

    always_comb begin
        running = live_q.en && (live_q.phase != '0) && (live_q.modulo != '0);
        step    = (live_q.phase > live_q.modulo) ? live_q.modulo : live_q.phase;
        sum     = {1'b0, acc_q} + {1'b0, step};
        wrap    = running && (sum >= {1'b0, live_q.modulo});
        load    = pend_v_q && (!running || wrap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            live_q   <= '0;
            pend_v_q <= 1'b0;
            acc_q    <= '0;
            out_q    <= 1'b0;
        end else begin
            out_q <= running ? wrap : !live_q.en;
            if (load) begin
                live_q <= pend_q;
                acc_q  <= '0;
            end else if (running) begin
                acc_q <= wrap ? ACC_W'(sum - {1'b0, live_q.modulo}) : sum[ACC_W-1:0];
            end
            if (wr) begin
                pend_q   <= wr_cfg;
                pend_v_q <= 1'b1;
            end else if (load) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    assign pulse   = out_q;
    assign live_en = live_q.en;

    a_r2_bypass_high: assert property (@(posedge clk) disable iff (rst)
        !live_q.en |=> out_q);
    a_r5_zero_phase_silent: assert property (@(posedge clk) disable iff (rst)
        (live_q.en && live_q.phase == '0) |=> !out_q);
    a_r6_zero_mod_silent: assert property (@(posedge clk) disable iff (rst)
        (live_q.en && live_q.modulo == '0) |=> !out_q);
    a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
        (live_q.en && live_q.modulo != '0 && live_q.phase >= live_q.modulo) |=> out_q);
    a_r3_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
        running |-> (acc_q < live_q.modulo));
    a_r7_hold_until_wrap: assert property (@(posedge clk) disable iff (rst)
        (running && !wrap) |=> $stable(live_q));
endmodule

// File: rtl/clken_dto.sv
`timescale 1ns/1ps
module clken_dto
    import dto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [ACC_W-1:0]  cfg_phase,
    input  logic [ACC_W-1:0]  cfg_mod,
    input  logic              calc_wr,
    input  logic [FREQ_W-1:0] calc_req,
    input  logic [FREQ_W-1:0] calc_base,
    input  logic              zero_opt,
    output logic              clk_en,
    output logic              active,
    output logic              sat_err
);
    dto_cfg_t calc_cfg;
    logic     calc_sat;
    dto_cfg_t wr_cfg;
    logic     wr_any;
    logic     sat_q;

    dto_phase_calc u_calc (
        .want (calc_req),
        .base (calc_base),
        .zopt (zero_opt),
        .cfg  (calc_cfg),
        .sat  (calc_sat)
    );

    always_comb begin
        wr_any = cfg_wr || calc_wr;
        if (cfg_wr) begin
            wr_cfg.en     = cfg_en;
            wr_cfg.phase  = cfg_phase;
            wr_cfg.modulo = cfg_mod;
        end else begin
            wr_cfg = calc_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          sat_q <= 1'b0;
        else if (cfg_wr)  sat_q <= 1'b0;
        else if (calc_wr) sat_q <= calc_sat;
    end

    dto_core u_core (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_any),
        .wr_cfg  (wr_cfg),
        .pulse   (clk_en),
        .live_en (active)
    );

    assign sat_err = sat_q;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!clk_en && !active && !sat_err));
    a_r9_sat_from_derive: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_err) |-> $past(calc_wr && !cfg_wr));
    a_r11_direct_clears: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !sat_err);
endmodule

// File: tb/clken_dto_tb.sv
`timescale 1ns/1ps
module clken_dto_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_en = 1'b0;
    logic [7:0]  cfg_phase = '0;
    logic [7:0]  cfg_mod = '0;
    logic        calc_wr = 1'b0;
    logic [15:0] calc_req = '0;
    logic [15:0] calc_base = '0;
    logic        zero_opt = 1'b0;
    logic        clk_en;
    logic        active;
    logic        sat_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clken_dto u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_phase(cfg_phase), .cfg_mod(cfg_mod), .calc_wr(calc_wr),
        .calc_req(calc_req), .calc_base(calc_base), .zero_opt(zero_opt),
        .clk_en(clk_en), .active(active), .sat_err(sat_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_cfg(input bit en, input int p, input int m);
        cfg_en = en; cfg_phase = 8'(p); cfg_mod = 8'(m); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_calc(input int rq, input int bs, input bit zo);
        calc_req = 16'(rq); calc_base = 16'(bs); zero_opt = zo; calc_wr = 1'b1;
        @(negedge clk);
        calc_wr = 1'b0;
    endtask

    task automatic go_idle();
        wr_cfg(1'b0, 0, 0);
        repeat (260) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk("R2 bypass clk_en", int'(clk_en), 1);
            chk("R2 bypass active", int'(active), 0);
            @(negedge clk);
        end
    endtask

    function automatic int expect_bit(input int p, input int m, input int j);
        int pe;
        if (m == 0 || p == 0) return 0;
        pe = (p > m) ? m : p;
        return (j * pe) / m - ((j - 1) * pe) / m;
    endfunction

    // called right after the write task; checks the load cycle then n cycles
    task automatic run_pattern(input string tag, input int p, input int m, input int n,
                               input bit from_idle);
        @(negedge clk);
        chk({tag, " active"}, int'(active), 1);
        if (from_idle) chk("R7 immediate load (bypass cycle)", int'(clk_en), 1);
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            chk(tag, int'(clk_en), expect_bit(p, m, j));
        end
    endtask

    function automatic string tag_for(input int p, input int m);
        if (m == 0) return "R6 zero modulo";
        if (p == 0) return "R5 zero phase";
        if (p > m)  return "R4 phase above modulo";
        return "R3 pulse pattern";
    endfunction

    initial begin
        int mods[6] = '{1, 2, 3, 5, 8, 13};
        int big_p[7] = '{0, 1, 64, 127, 200, 254, 255};
        int rq_l[7] = '{500, 1000, 333, 1, 60000, 1001, 65535};
        int bs_l[7] = '{1000, 1000, 1000, 60000, 60000, 1000, 1};
        int seq[7] = '{0, 0, 1, 0, 1, 0, 1};

        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset clk_en", int'(clk_en), 0);
            chk("R1 reset active", int'(active), 0);
            chk("R1 reset sat_err", int'(sat_err), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle bypass", int'(clk_en), 1);
        chk("R1 first cycle active", int'(active), 0);

        // R3 R4 R5 small moduli sweep
        foreach (mods[i]) begin
            for (int p = 0; p <= mods[i] + 2; p++) begin
                go_idle();
                wr_cfg(1'b1, p, mods[i]);
                run_pattern(tag_for(p, mods[i]), p, mods[i], 2 * mods[i] + 2, 1'b1);
            end
        end
        // large modulo
        foreach (big_p[i]) begin
            go_idle();
            wr_cfg(1'b1, big_p[i], 255);
            run_pattern(tag_for(big_p[i], 255), big_p[i], 255, 257, 1'b1);
        end
        // R6 zero modulo
        go_idle();
        wr_cfg(1'b1, 7, 0);
        run_pattern(tag_for(7, 0), 7, 0, 20, 1'b1);

        // R7 deferred update
        go_idle();
        wr_cfg(1'b1, 1, 4);
        @(negedge clk);
        for (int j = 1; j <= 5; j++) begin
            @(negedge clk);
            chk("R7 before rewrite", int'(clk_en), expect_bit(1, 4, j));
        end
        wr_cfg(1'b1, 1, 2);
        chk("R7 deferred j6", int'(clk_en), seq[0]);
        for (int j = 7; j <= 12; j++) begin
            @(negedge clk);
            chk("R7 deferred update", int'(clk_en), seq[j - 6]);
        end

        // R8 R9 derived phase
        foreach (rq_l[i]) begin
            longint e;
            e = (255 * longint'(rq_l[i]) + bs_l[i] - 1) / bs_l[i];
            go_idle();
            wr_calc(rq_l[i], bs_l[i], 1'b0);
            chk("R9 sat_err", int'(sat_err), (e > 255) ? 1 : 0);
            run_pattern((e > 255) ? "R9 clamped phase" : "R8 derived phase",
                        (e > 255) ? 255 : int'(e), 255, 257, 1'b1);
        end
        // R9 cleared by a non-saturating derive write
        go_idle();
        wr_calc(1001, 1000, 1'b0);
        chk("R9 sat set", int'(sat_err), 1);
        wr_calc(0, 1000, 1'b1);
        chk("R9 sat cleared by derive", int'(sat_err), 0);

        // R10 zero operand
        go_idle();
        wr_calc(0, 1000, 1'b1);
        run_pattern("R10 zero request zero-rate", 0, 1, 20, 1'b1);
        go_idle();
        wr_calc(77, 0, 1'b1);
        run_pattern("R10 zero base zero-rate", 0, 1, 20, 1'b1);
        go_idle();
        wr_calc(0, 1000, 1'b0);
        @(negedge clk);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            chk("R10 bypass clk_en", int'(clk_en), 1);
            chk("R10 bypass active", int'(active), 0);
        end

        // R11 simultaneous writes
        go_idle();
        wr_calc(1001, 1000, 1'b0);
        chk("R11 pre sat", int'(sat_err), 1);
        cfg_en = 1'b1; cfg_phase = 8'd1; cfg_mod = 8'd3; cfg_wr = 1'b1;
        calc_req = 16'd65535; calc_base = 16'd1; zero_opt = 1'b0; calc_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; calc_wr = 1'b0;
        chk("R11 sat cleared", int'(sat_err), 0);
        run_pattern("R11 direct wins", 1, 3, 9, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule